// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register file of a descriptor-driven DMA controller. Each channel has its own 8 KiB window on a 32-bit memory-mapped bus. The window holds the pointers the channel engine walks (current data descriptor, saved descriptor, saved buffer position, group and group-down context), a command register, a configuration register and a set of interrupt registers. The descriptor fetch and the data movement sit in a separate engine. That engine receives single-cycle strobes from this block and sends back interrupt-set pulses and a few status flags.

The channel state is one-hot and follows configuration writes. The start strobe moves it to running. A status read builds a word from that state, the engine's end-of-list flag and the engine's stream-command source. A stream-command write is decoded bit by bit into data-descriptor load, context load and start strobes. A command write requests a continue, which is issued only when the channel conditions allow it. Raw interrupt bits accumulate from the engine and are cleared by writing the self-clearing acknowledge register. Each channel has one interrupt line, formed from raw AND mask.

Top module: `dmach_regbank`

## Requirements
- R1: After reset every stored register reads 0, the status word reads 0x1 (state RESET) plus the engine flag fields, and all strobes and interrupt lines are low.
- R2: The channel is selected by address bits 13 and up, and the register by address bits 7:0 (byte offsets: data pointer 0x00, saved descriptor 0x58, saved buffer 0x5C, group 0x60, group-down 0x7C, command 0x80, config 0x84, status 0x88, mask 0x8C, acknowledge 0x90, raw 0x94, masked 0x98, stream command 0x9C). A pointer written in one channel reads back there, leaves other channels untouched, and drives that channel's pointer outputs.
- R3: A config write with bit 0 clear forces state RESET (0x1). Otherwise, a config write with bit 1 set forces STOPPED (0x2). A config write with bit 0 set and bit 1 clear leaves the state unchanged.
- R4: A status read returns the one-hot state in bits 2:0 (RESET 1, STOPPED 2, RUNNING 4), the engine end-of-list flag in bit 5, the engine stream source in bits 15:8, and zero elsewhere. Writes to status have no effect.
- R5: A stream-command write uses bits 9:0 only. If bit 8 or bit 6 is set, it strobes a data-descriptor load. If bit 5 is set as well, it also strobes start. If bit 9 is set, it strobes a context load. Each strobe is high for the single cycle after the write. Start sets state RUNNING (0x4) when config bit 0 is 1 and config bit 1 is 0.
- R6: A command write strobes continue in the next cycle only when config bit 0 is 1, config bit 1 is 0, the state is RUNNING, and the engine reports end-of-list on the current descriptor.
- R7: A one-cycle engine set pulse sets raw interrupt bits. An acknowledge write clears the raw bits that are 1 in the written value. When a set and a clear hit the same bit in the same cycle, the set wins. The acknowledge register always reads 0.
- R8: The masked register equals raw AND mask, and each channel's interrupt line is high exactly when its masked value is nonzero.
- R9: Accesses with byte enables other than 4'hF, or with address bits 1:0 nonzero, are ignored and read as 0. Unimplemented offsets read as 0.
- R10: Read data and its valid flag appear in the cycle after the read request. Valid is low in cycles after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | CH_W+13 | Byte address; channel in the top bits |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| eng_intr_set | input | NCH*IRQ_W | Per-channel raw interrupt set pulses |
| eng_desc_eol | input | NCH | Current data descriptor has end-of-list set |
| eng_list_end | input | NCH | Channel has reached end of list |
| eng_src | input | NCH*8 | Stream-command source per channel |
| irq | output | NCH | Interrupt line per channel |
| ld_desc | output | NCH | Data-descriptor load strobe |
| ld_ctx | output | NCH | Context load strobe |
| start | output | NCH | Channel start strobe |
| cont | output | NCH | Continue strobe |
| desc_ptr | output | NCH*32 | Saved descriptor pointer per channel |
| buf_ptr | output | NCH*32 | Saved buffer pointer per channel |
| ctx_ptr | output | NCH*32 | Group-down context pointer per channel |

## Verification
The properties assume that reads return data in the cycle after a request and that strobes arise only from writes. They also assume that the engine's set pulses and flags change only between bus accesses the block can see. A guard flag delays every history-based property by one cycle after reset, so a request left asserted during reset cannot cause a false hit. The stimulus changes all inputs on the falling clock edge and issues at most one access per cycle. Each set pulse lasts exactly one cycle. The only deliberate overlap is a set pulse in the same cycle as an acknowledge write of the same bit.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  localparam int WIN_LSB = 13;
  localparam int OFF_W   = 8;

  localparam logic [OFF_W-1:0] OFF_DATA  = 8'h00;
  localparam logic [OFF_W-1:0] OFF_SDESC = 8'h58;
  localparam logic [OFF_W-1:0] OFF_SBUF  = 8'h5C;
  localparam logic [OFF_W-1:0] OFF_GRP   = 8'h60;
  localparam logic [OFF_W-1:0] OFF_GDN   = 8'h7C;
  localparam logic [OFF_W-1:0] OFF_CMD   = 8'h80;
  localparam logic [OFF_W-1:0] OFF_CFG   = 8'h84;
  localparam logic [OFF_W-1:0] OFF_STAT  = 8'h88;
  localparam logic [OFF_W-1:0] OFF_MASK  = 8'h8C;
  localparam logic [OFF_W-1:0] OFF_ACK   = 8'h90;
  localparam logic [OFF_W-1:0] OFF_RAW   = 8'h94;
  localparam logic [OFF_W-1:0] OFF_MSKD  = 8'h98;
  localparam logic [OFF_W-1:0] OFF_STRM  = 8'h9C;

  localparam logic [9:0] STRM_LOAD_D = 10'h140;
  localparam logic [9:0] STRM_BURST  = 10'h020;
  localparam logic [9:0] STRM_LOAD_C = 10'h200;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_SDESC, SEL_SBUF, SEL_GRP, SEL_GDN, SEL_CMD,
    SEL_CFG, SEL_STAT, SEL_MASK, SEL_ACK, SEL_RAW, SEL_MSKD, SEL_STRM
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_RESET   = 3'b001,
    ST_STOPPED = 3'b010,
    ST_RUNNING = 3'b100
  } ch_state_e;

endpackage

// File: rtl/dmach_decode.sv
module dmach_decode
  import dmach_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  output reg_sel_e         sel
);

  always_comb begin
    unique case (off)
      OFF_DATA:  sel = SEL_DATA;
      OFF_SDESC: sel = SEL_SDESC;
      OFF_SBUF:  sel = SEL_SBUF;
      OFF_GRP:   sel = SEL_GRP;
      OFF_GDN:   sel = SEL_GDN;
      OFF_CMD:   sel = SEL_CMD;
      OFF_CFG:   sel = SEL_CFG;
      OFF_STAT:  sel = SEL_STAT;
      OFF_MASK:  sel = SEL_MASK;
      OFF_ACK:   sel = SEL_ACK;
      OFF_RAW:   sel = SEL_RAW;
      OFF_MSKD:  sel = SEL_MSKD;
      OFF_STRM:  sel = SEL_STRM;
      default:   sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/dmach_irq.sv
module dmach_irq #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mask,
  input  logic             wr_ack,
  input  logic [IRQ_W-1:0] wbits,
  input  logic [IRQ_W-1:0] set_pulse,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);

  logic [IRQ_W-1:0] raw_q, raw_d, clr_bits;
  logic [IRQ_W-1:0] mask_q;
  logic             raw_en;

  always_comb begin
    clr_bits = wr_ack ? wbits : '0;
    raw_d    = (raw_q & ~clr_bits) | set_pulse;
    raw_en   = wr_ack | (|set_pulse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= wbits;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = raw_q & mask_q;
  assign irq    = |masked;

endmodule

// File: rtl/dmach_chan.sv
module dmach_chan
  import dmach_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [31:0]      wdata,
  input  logic [IRQ_W-1:0] intr_set,
  input  logic             desc_eol,
  input  logic             list_end,
  input  logic [7:0]       src,
  output logic [31:0]      rd_val,
  output logic             irq,
  output logic             ld_desc,
  output logic             ld_ctx,
  output logic             start,
  output logic             cont,
  output logic [31:0]      desc_ptr,
  output logic [31:0]      buf_ptr,
  output logic [31:0]      ctx_ptr
);

  localparam int PAD_W = 32 - IRQ_W;

  logic [31:0] data_q, sdesc_q, sbuf_q, grp_q, gdn_q, cmd_q, cfg_q, strm_q;
  ch_state_e   state_q, state_d;
  logic        ld_desc_q, ld_ctx_q, start_q, cont_q;
  logic        ld_desc_d, ld_ctx_d, start_d, cont_d;
  logic        cfg_go;
  logic [9:0]  scmd;
  logic [IRQ_W-1:0] raw, mask, masked;

  dmach_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mask   (wr && (sel == SEL_MASK)),
    .wr_ack    (wr && (sel == SEL_ACK)),
    .wbits     (wdata[IRQ_W-1:0]),
    .set_pulse (intr_set),
    .raw       (raw),
    .mask      (mask),
    .masked    (masked),
    .irq       (irq)
  );

  // Next-state and strobe decode
  always_comb begin
    scmd      = wdata[9:0];
    cfg_go    = cfg_q[0] && !cfg_q[1];
    ld_desc_d = wr && (sel == SEL_STRM) && |(scmd & STRM_LOAD_D);
    start_d   = ld_desc_d && |(scmd & STRM_BURST);
    ld_ctx_d  = wr && (sel == SEL_STRM) && |(scmd & STRM_LOAD_C);
    cont_d    = wr && (sel == SEL_CMD) && cfg_go &&
                (state_q == ST_RUNNING) && desc_eol;
    state_d   = state_q;
    if (wr && (sel == SEL_CFG)) begin
      if (!wdata[0]) begin
        state_d = ST_RESET;
      end else if (wdata[1]) begin
        state_d = ST_STOPPED;
      end
    end else if (start_d && cfg_go) begin
      state_d = ST_RUNNING;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RESET;
      ld_desc_q <= 1'b0;
      ld_ctx_q  <= 1'b0;
      start_q   <= 1'b0;
      cont_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      ld_desc_q <= ld_desc_d;
      ld_ctx_q  <= ld_ctx_d;
      start_q   <= start_d;
      cont_q    <= cont_d;
    end
  end

  // Stored registers, each with its own write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      sdesc_q <= '0;
      sbuf_q  <= '0;
      grp_q   <= '0;
      gdn_q   <= '0;
      cmd_q   <= '0;
      cfg_q   <= '0;
      strm_q  <= '0;
    end else begin
      if (wr && (sel == SEL_DATA))  data_q  <= wdata;
      if (wr && (sel == SEL_SDESC)) sdesc_q <= wdata;
      if (wr && (sel == SEL_SBUF))  sbuf_q  <= wdata;
      if (wr && (sel == SEL_GRP))   grp_q   <= wdata;
      if (wr && (sel == SEL_GDN))   gdn_q   <= wdata;
      if (wr && (sel == SEL_CMD))   cmd_q   <= wdata;
      if (wr && (sel == SEL_CFG))   cfg_q   <= wdata;
      if (wr && (sel == SEL_STRM))  strm_q  <= wdata;
    end
  end

  // Read value for the selected offset
  always_comb begin
    unique case (sel)
      SEL_DATA:  rd_val = data_q;
      SEL_SDESC: rd_val = sdesc_q;
      SEL_SBUF:  rd_val = sbuf_q;
      SEL_GRP:   rd_val = grp_q;
      SEL_GDN:   rd_val = gdn_q;
      SEL_CMD:   rd_val = cmd_q;
      SEL_CFG:   rd_val = cfg_q;
      SEL_STAT:  rd_val = {16'h0, src, 2'b00, list_end, 2'b00, state_q};
      SEL_MASK:  rd_val = {{PAD_W{1'b0}}, mask};
      SEL_RAW:   rd_val = {{PAD_W{1'b0}}, raw};
      SEL_MSKD:  rd_val = {{PAD_W{1'b0}}, masked};
      SEL_STRM:  rd_val = strm_q;
      default:   rd_val = '0;
    endcase
  end

  assign ld_desc  = ld_desc_q;
  assign ld_ctx   = ld_ctx_q;
  assign start    = start_q;
  assign cont     = cont_q;
  assign desc_ptr = sdesc_q;
  assign buf_ptr  = sbuf_q;
  assign ctx_ptr  = gdn_q;

endmodule

// File: rtl/dmach_regbank.sv
module dmach_regbank
  import dmach_pkg::*;
#(
  parameter int CH_W  = 1,
  parameter int IRQ_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_req,
  input  logic                           bus_we,
  input  logic [CH_W+12:0]               bus_addr,
  input  logic [3:0]                     bus_be,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  output logic                           bus_rvalid,
  input  logic [(1<<CH_W)*IRQ_W-1:0]     eng_intr_set,
  input  logic [(1<<CH_W)-1:0]           eng_desc_eol,
  input  logic [(1<<CH_W)-1:0]           eng_list_end,
  input  logic [(1<<CH_W)*8-1:0]         eng_src,
  output logic [(1<<CH_W)-1:0]           irq,
  output logic [(1<<CH_W)-1:0]           ld_desc,
  output logic [(1<<CH_W)-1:0]           ld_ctx,
  output logic [(1<<CH_W)-1:0]           start,
  output logic [(1<<CH_W)-1:0]           cont,
  output logic [(1<<CH_W)*32-1:0]        desc_ptr,
  output logic [(1<<CH_W)*32-1:0]        buf_ptr,
  output logic [(1<<CH_W)*32-1:0]        ctx_ptr
);

  localparam int NCH = 1 << CH_W;

  logic            word_ok, rd_req;
  logic [CH_W-1:0] ch_idx;
  reg_sel_e        sel;
  logic [31:0]     rd_val [NCH];
  logic [31:0]     rdata_d;
  logic            addr_unused;

  assign word_ok     = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  assign ch_idx      = bus_addr[WIN_LSB +: CH_W];
  assign rd_req      = bus_req && !bus_we;
  assign addr_unused = ^bus_addr[WIN_LSB-1:OFF_W];

  dmach_decode u_dec (
    .off (bus_addr[OFF_W-1:0]),
    .sel (sel)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmach_chan #(.IRQ_W(IRQ_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_req && bus_we && word_ok && (ch_idx == CH_W'(g))),
      .sel      (sel),
      .wdata    (bus_wdata),
      .intr_set (eng_intr_set[g*IRQ_W +: IRQ_W]),
      .desc_eol (eng_desc_eol[g]),
      .list_end (eng_list_end[g]),
      .src      (eng_src[g*8 +: 8]),
      .rd_val   (rd_val[g]),
      .irq      (irq[g]),
      .ld_desc  (ld_desc[g]),
      .ld_ctx   (ld_ctx[g]),
      .start    (start[g]),
      .cont     (cont[g]),
      .desc_ptr (desc_ptr[g*32 +: 32]),
      .buf_ptr  (buf_ptr[g*32 +: 32]),
      .ctx_ptr  (ctx_ptr[g*32 +: 32])
    );
  end

  assign rdata_d = word_ok ? rd_val[ch_idx] : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_req) begin
      bus_rdata <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
    end
  end

endmodule

// File: rtl/dmach_regbank_chk.sv
module dmach_regbank_chk #(
  parameter int CH_W = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_req,
  input logic                  bus_we,
  input logic [3:0]            bus_be,
  input logic [31:0]           bus_rdata,
  input logic                  bus_rvalid,
  input logic [(1<<CH_W)-1:0]  ld_desc,
  input logic [(1<<CH_W)-1:0]  ld_ctx,
  input logic [(1<<CH_W)-1:0]  start,
  input logic [(1<<CH_W)-1:0]  cont
);

  localparam int NCH = 1 << CH_W;

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R10: valid follows a read request by one cycle
  a_r10_rvalid_timing: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (bus_rvalid == $past(bus_req && !bus_we)));

  // R9: a partial-width read returns zero
  a_r9_partial_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_rvalid && $past(bus_be != 4'hF)) |-> (bus_rdata == 32'h0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R5: start never comes without a data-descriptor load
    a_r5_start_with_load: assert property (@(posedge clk) disable iff (!rst_n)
      start[g] |-> ld_desc[g]);

    // R5: load strobes follow a bus write
    a_r5_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (ld_desc[g] || ld_ctx[g])) |-> $past(bus_req && bus_we));

    // R6: continue follows a full-word bus write
    a_r6_cont_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cont[g]) |-> $past(bus_req && bus_we && (bus_be == 4'hF)));
  end

endmodule

bind dmach_regbank dmach_regbank_chk #(.CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_be     (bus_be),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .ld_desc    (ld_desc),
  .ld_ctx     (ld_ctx),
  .start      (start),
  .cont       (cont)
);

// File: tb/sim_dmach_regbank.sv
module sim_dmach_regbank;

  localparam int CH_W  = 1;
  localparam int IRQ_W = 4;
  localparam int NCH   = 1 << CH_W;

  logic                     clk, rst_n;
  logic                     bus_req, bus_we;
  logic [CH_W+12:0]         bus_addr;
  logic [3:0]               bus_be;
  logic [31:0]              bus_wdata, bus_rdata;
  logic                     bus_rvalid;
  logic [NCH*IRQ_W-1:0]     eng_intr_set;
  logic [NCH-1:0]           eng_desc_eol, eng_list_end;
  logic [NCH*8-1:0]         eng_src;
  logic [NCH-1:0]           irq, ld_desc, ld_ctx, start, cont;
  logic [NCH*32-1:0]        desc_ptr, buf_ptr, ctx_ptr;

  int n_chk, n_fail;
  logic s_ld, s_lc, s_st, s_ct;
  logic [31:0] r_data;
  logic        r_valid;

  dmach_regbank #(.CH_W(CH_W), .IRQ_W(IRQ_W)) u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic        ch;
    logic [7:0]  off;
    logic [31:0] d;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{1'b1, 1'b0, 8'h00, 32'h1111_0000},
    '{1'b1, 1'b0, 8'h58, 32'h2000_0040},
    '{1'b1, 1'b1, 8'h58, 32'hABCD_0010},
    '{1'b1, 1'b0, 8'h7C, 32'h3000_0100},
    '{1'b1, 1'b1, 8'h60, 32'h0F0F_0F0F},
    '{1'b1, 1'b0, 8'h40, 32'hFFFF_FFFF},
    '{1'b0, 1'b0, 8'h00, 32'h1111_0000},
    '{1'b0, 1'b0, 8'h58, 32'h2000_0040},
    '{1'b0, 1'b1, 8'h58, 32'hABCD_0010},
    '{1'b0, 1'b1, 8'h00, 32'h0000_0000},
    '{1'b0, 1'b1, 8'h60, 32'h0F0F_0F0F},
    '{1'b0, 1'b0, 8'h40, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] off, input logic [31:0] d,
                    input logic [3:0] be = 4'hF, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    bus_req   = 1'b1;
    bus_we    = 1'b1;
    bus_addr  = {ch[CH_W-1:0], 5'd0, off[7:2], lo};
    bus_wdata = d;
    bus_be    = be;
    @(negedge clk);
    bus_req = 1'b0;
    bus_we  = 1'b0;
    s_ld = ld_desc[ch];
    s_lc = ld_ctx[ch];
    s_st = start[ch];
    s_ct = cont[ch];
  endtask

  task automatic rd(input int ch, input logic [7:0] off, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req  = 1'b1;
    bus_we   = 1'b0;
    bus_addr = {ch[CH_W-1:0], 5'd0, off};
    bus_be   = be;
    @(negedge clk);
    bus_req = 1'b0;
    r_data  = bus_rdata;
    r_valid = bus_rvalid;
  endtask

  task automatic pulse(input int ch, input logic [IRQ_W-1:0] bits);
    @(negedge clk);
    eng_intr_set[ch*IRQ_W +: IRQ_W] = bits;
    @(negedge clk);
    eng_intr_set = '0;
  endtask

  task automatic chk_strobes(input string req, input logic [3:0] exp);
    chk(req, {28'h0, s_ld, s_lc, s_st, s_ct}, {28'h0, exp});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = 4'hF; bus_wdata = '0;
    eng_intr_set = '0; eng_desc_eol = '0; eng_list_end = '0; eng_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 strobes", {28'h0, ld_desc[0], ld_ctx[0], start[0], cont[0]}, 32'h0);
    chk("R1 irq", {30'h0, irq}, 32'h0);
    rd(0, 8'h88); chk("R1 status", r_data, 32'h1);
    rd(1, 8'h84); chk("R1 cfg", r_data, 32'h0);
    rd(0, 8'h94); chk("R1 raw", r_data, 32'h0);

    // R2, R9: vector table
    foreach (TBL[i]) begin
      if (TBL[i].wr) begin
        wr(int'(TBL[i].ch), TBL[i].off, TBL[i].d);
      end else begin
        rd(int'(TBL[i].ch), TBL[i].off);
        chk($sformatf("R2 vec %0d", i), r_data, TBL[i].d);
      end
    end
    chk("R2 desc_ptr ch0", desc_ptr[31:0], 32'h2000_0040);
    chk("R2 desc_ptr ch1", desc_ptr[63:32], 32'hABCD_0010);
    chk("R2 ctx_ptr ch0", ctx_ptr[31:0], 32'h3000_0100);
    chk("R2 buf_ptr ch1", buf_ptr[63:32], 32'h0);

    // R3, R4: config and status
    eng_list_end[0] = 1'b1;
    eng_src[7:0]    = 8'h5A;
    wr(0, 8'h84, 32'h1);
    rd(0, 8'h88); chk("R3 enable keeps RESET", r_data, 32'h5A21);
    wr(0, 8'h84, 32'h3);
    rd(0, 8'h88); chk("R3 stop -> STOPPED", r_data, 32'h5A22);
    wr(0, 8'h88, 32'hFFFF_FFFF);
    rd(0, 8'h88); chk("R4 status write ignored", r_data, 32'h5A22);
    wr(0, 8'h84, 32'h2);
    rd(0, 8'h88); chk("R3 disable beats stop", r_data, 32'h5A21);
    rd(1, 8'h88); chk("R4 other channel status", r_data, 32'h1);
    eng_list_end = '0;
    eng_src      = '0;

    // R5: stream command decode
    wr(0, 8'h84, 32'h1);
    wr(0, 8'h9C, 32'h040); chk_strobes("R5 bit6 load", 4'b1000);
    wr(0, 8'h9C, 32'h100); chk_strobes("R5 bit8 load", 4'b1000);
    wr(0, 8'h9C, 32'h200); chk_strobes("R5 ctx load", 4'b0100);
    wr(0, 8'h9C, 32'h020); chk_strobes("R5 burst alone", 4'b0000);
    wr(0, 8'h9C, 32'hFFFF_FC00); chk_strobes("R5 upper bits", 4'b0000);
    rd(0, 8'h88); chk("R5 no start keeps RESET", r_data, 32'h1);
    wr(0, 8'h9C, 32'h060); chk_strobes("R5 load+start", 4'b1010);
    rd(0, 8'h88); chk("R5 start -> RUNNING", r_data, 32'h4);
    chk("R5 strobe one cycle", {31'h0, ld_desc[0]}, 32'h0);

    // R6: continue conditions
    wr(0, 8'h80, 32'h1); chk_strobes("R6 no desc eol", 4'b0000);
    eng_desc_eol[0] = 1'b1;
    wr(0, 8'h80, 32'h1); chk_strobes("R6 continue", 4'b0001);
    wr(0, 8'h84, 32'h3);
    wr(0, 8'h80, 32'h1); chk_strobes("R6 stopped", 4'b0000);
    wr(0, 8'h84, 32'h1);
    wr(0, 8'h80, 32'h1); chk_strobes("R6 not running", 4'b0000);
    wr(0, 8'h9C, 32'h160);
    wr(0, 8'h80, 32'h1); chk_strobes("R6 running again", 4'b0001);
    wr(0, 8'h84, 32'h0);
    wr(0, 8'h80, 32'h1); chk_strobes("R6 disabled", 4'b0000);
    eng_desc_eol = '0;

    // R7, R8: interrupts
    wr(0, 8'h8C, 32'h4);
    pulse(0, 4'h4);
    chk("R8 irq on masked bit", {30'h0, irq}, 32'h1);
    pulse(0, 4'h1);
    rd(0, 8'h94); chk("R7 raw accumulates", r_data, 32'h5);
    rd(0, 8'h98); chk("R8 masked", r_data, 32'h4);
    wr(0, 8'h90, 32'h4);
    rd(0, 8'h94); chk("R7 ack clears", r_data, 32'h1);
    chk("R8 irq drops", {30'h0, irq}, 32'h0);
    rd(0, 8'h90); chk("R7 ack reads zero", r_data, 32'h0);
    wr(0, 8'h8C, 32'h1);
    chk("R8 irq after mask", {30'h0, irq}, 32'h1);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_be = 4'hF;
    bus_addr = {1'b0, 5'd0, 8'h90}; bus_wdata = 32'h1;
    eng_intr_set[3:0] = 4'h1;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; eng_intr_set = '0;
    rd(0, 8'h94); chk("R7 set beats ack", r_data, 32'h1);
    wr(0, 8'h90, 32'h1);
    rd(0, 8'h94); chk("R7 final ack", r_data, 32'h0);
    chk("R8 irq low", {30'h0, irq}, 32'h0);

    // R9: non-word accesses
    wr(0, 8'h00, 32'hDEAD_BEEF, 4'h3);
    wr(0, 8'h00, 32'hDEAD_BEEF, 4'hF, 2'b10);
    rd(0, 8'h00); chk("R9 partial writes ignored", r_data, 32'h1111_0000);
    rd(0, 8'h00, 4'h1); chk("R9 partial read zero", r_data, 32'h0);
    chk("R10 rvalid on read", {31'h0, r_valid}, 32'h1);
    @(negedge clk);
    chk("R10 rvalid idle", {31'h0, bus_rvalid}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule